// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block works out the effective address of the operand for a load instruction that takes two words: an opcode word that holds a 4-bit mode code, and a second word that holds a 16-bit address field. The caller pulses `start` together with the mode and address field. It also supplies the program counter, which by then has already moved past both instruction words. It supplies three register values as well: the selected general register (read from the register file), the index register and the base register. All these inputs are sampled on the clock edge where `start` is high.

Most modes finish one cycle after `start`. Indirect mode needs one more lookup in memory. The block requests that read on a port whose data must be valid in the same cycle as the request, and it finishes one cycle after the request. The two pointer modes also return a new value for the selected register on a write-back port. Two flags mark the cases where the operand is not in memory: a register-operand flag for register mode and an immediate flag for immediate mode. An implied flag covers implied mode, where the operand is the accumulator or the stack top. Mode codes outside the defined set raise an illegal-mode flag.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode code 2 (direct) gives an effective address equal to the address field.
- R2: Mode code 3 (indirect) asserts `mem_rd_en` for exactly one cycle, the cycle after `start`, with `mem_rd_addr` equal to the address field. `done` follows one cycle later, with the effective address equal to the `mem_rd_data` word returned for that request.
- R3: Mode code 5 (register indirect) gives an effective address equal to `reg_val`.
- R4: Mode code 4 (register) raises `reg_op` and drives an effective address of zero.
- R5: Mode code 6 (post-increment) gives an effective address equal to `reg_val`. It pulses `ptr_wr_en` with `ptr_wr_data` = `reg_val`+1 (mod 2^16).
- R6: Mode code 7 (pre-decrement) gives an effective address of `reg_val`−1 (mod 2^16). It pulses `ptr_wr_en` with that same value; for example, 400 gives 399.
- R7: Mode code 8 (PC-relative) gives `pc_next` + address field (mod 2^16). For example, `pc_next` 202 and field 500 give 702.
- R8: Mode code 9 (indexed) gives `idx_val` + field, and mode code 10 (base) gives `base_val` + field, both mod 2^16.
- R9: Mode code 1 (immediate) raises `imm_op` and gives `pc_next`−1, which is the location of the second instruction word.
- R10: Mode code 0 (implied) raises `implied_op` and drives an effective address of zero.
- R11: Mode codes 11 to 15 raise `illegal_mode`, drive an effective address of zero and give no write-back. At most one of `imm_op`, `reg_op`, `implied_op` and `illegal_mode` is high at any time.
- R12: Every mode other than indirect pulses `done` in the cycle after `start`. `start` has no effect while an indirect lookup is in progress. `ptr_wr_en` is only ever high together with `done`, and only for the codes in R5 and R6.
- R13: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation with the inputs sampled at this edge |
| mode | input | 4 | Addressing mode code |
| addr_field | input | 16 | Address word of the instruction |
| pc_next | input | 16 | Program counter, already past both instruction words |
| reg_val | input | 16 | Content of the selected general register |
| idx_val | input | 16 | Index register content |
| base_val | input | 16 | Base register content |
| mem_rd_en | output | 1 | Memory read request for indirect mode |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, valid while `mem_rd_en` is high |
| eff_addr | output | 16 | Effective address, valid while `done` is high and held until the next `done` |
| imm_op | output | 1 | Operand is the address word itself |
| reg_op | output | 1 | Operand is the selected register |
| implied_op | output | 1 | Operand is the accumulator or the stack top |
| illegal_mode | output | 1 | Mode code is reserved |
| done | output | 1 | Result strobe |
| ptr_wr_en | output | 1 | Write-back enable for the selected register |
| ptr_wr_data | output | 16 | New value for the selected register |

## Verification
The assertions take for granted that `mem_rd_data` is stable and valid throughout any cycle in which `mem_rd_en` is high. The bench keeps within this by modelling memory as a combinational function of `mem_rd_addr`. The assertions also assume that `start` may come at any time, and that a `start` arriving during an indirect lookup is simply dropped. The stimulus checks that a dropped `start` produces no `done`. Random mode codes cover the reserved range as well, and random register and field values exercise wrap-around at 2^16.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int ADDR_W  = 16;
    localparam int MODE_W  = 4;
    localparam int N_MODES = 11;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPLIED  = 4'd0,
        AM_IMM      = 4'd1,
        AM_DIRECT   = 4'd2,
        AM_INDIRECT = 4'd3,
        AM_REG      = 4'd4,
        AM_REG_IND  = 4'd5,
        AM_POST_INC = 4'd6,
        AM_PRE_DEC  = 4'd7,
        AM_PC_REL   = 4'd8,
        AM_INDEXED  = 4'd9,
        AM_BASE     = 4'd10
    } am_e;

    typedef struct packed {
        addr_t ea;
        addr_t wb_data;
        logic  wb_en;
        logic  imm;
        logic  regop;
        logic  impl;
        logic  illegal;
        logic  mem;
    } calc_t;

    function automatic logic mode_legal(mode_t m);
        return int'(m) < N_MODES;
    endfunction

    function automatic addr_t add_wrap(addr_t a, addr_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/eag_calc.sv
module eag_calc
    import eag_pkg::*;
(
    input  mode_t mode,
    input  addr_t field,
    input  addr_t pc_next,
    input  addr_t reg_val,
    input  addr_t idx_val,
    input  addr_t base_val,
    output calc_t res
);
    localparam addr_t ONE    = addr_t'(1);
    localparam addr_t NEG1   = '1;

    always_comb begin
        res = '0;
        if (!mode_legal(mode)) begin
            res.illegal = 1'b1;
        end else begin
            case (am_e'(mode))
                AM_IMPLIED:  res.impl = 1'b1;
                AM_IMM: begin
                    res.imm = 1'b1;
                    res.ea  = add_wrap(pc_next, NEG1);
                end
                AM_DIRECT:   res.ea  = field;
                AM_INDIRECT: res.mem = 1'b1;
                AM_REG:      res.regop = 1'b1;
                AM_REG_IND:  res.ea  = reg_val;
                AM_POST_INC: begin
                    res.ea      = reg_val;
                    res.wb_en   = 1'b1;
                    res.wb_data = add_wrap(reg_val, ONE);
                end
                AM_PRE_DEC: begin
                    res.ea      = add_wrap(reg_val, NEG1);
                    res.wb_en   = 1'b1;
                    res.wb_data = add_wrap(reg_val, NEG1);
                end
                AM_PC_REL:   res.ea = add_wrap(pc_next, field);
                AM_INDEXED:  res.ea = add_wrap(idx_val, field);
                AM_BASE:     res.ea = add_wrap(base_val, field);
                default:     res.illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  calc_t res,
    input  addr_t field,
    input  addr_t mem_rd_data,
    output logic  mem_rd_en,
    output addr_t mem_rd_addr,
    output addr_t eff_addr,
    output logic  imm_op,
    output logic  reg_op,
    output logic  implied_op,
    output logic  illegal_mode,
    output logic  done,
    output logic  ptr_wr_en,
    output addr_t ptr_wr_data
);
    typedef enum logic {S_IDLE, S_MEM} state_e;
    state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            mem_rd_en    <= 1'b0;
            mem_rd_addr  <= '0;
            eff_addr     <= '0;
            imm_op       <= 1'b0;
            reg_op       <= 1'b0;
            implied_op   <= 1'b0;
            illegal_mode <= 1'b0;
            done         <= 1'b0;
            ptr_wr_en    <= 1'b0;
            ptr_wr_data  <= '0;
        end else begin
            done      <= 1'b0;
            ptr_wr_en <= 1'b0;
            mem_rd_en <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    imm_op       <= res.imm;
                    reg_op       <= res.regop;
                    implied_op   <= res.impl;
                    illegal_mode <= res.illegal;
                    if (res.mem) begin
                        mem_rd_en   <= 1'b1;
                        mem_rd_addr <= field;
                        state       <= S_MEM;
                    end else begin
                        eff_addr    <= res.ea;
                        done        <= 1'b1;
                        ptr_wr_en   <= res.wb_en;
                        ptr_wr_data <= res.wb_data;
                    end
                end
                S_MEM: begin
                    eff_addr <= mem_rd_data;
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_mem_req_R2: assert property (@(posedge clk) disable iff (rst)
        (start && state == S_IDLE && res.mem) |=> (mem_rd_en && mem_rd_addr == $past(field)));
    assert_mem_done_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (done && !mem_rd_en && eff_addr == $past(mem_rd_data)));
    assert_fast_done_R12: assert property (@(posedge clk) disable iff (rst)
        (start && state == S_IDLE && !res.mem) |=> done);
    assert_wb_with_done_R12: assert property (@(posedge clk) disable iff (rst)
        ptr_wr_en |-> done);
    assert_flags_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({imm_op, reg_op, implied_op, illegal_mode}));
    assert_illegal_no_wb_R11: assert property (@(posedge clk) disable iff (rst)
        (done && illegal_mode) |-> (!ptr_wr_en && eff_addr == '0));
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  mode,
    input  logic [15:0] addr_field,
    input  logic [15:0] pc_next,
    input  logic [15:0] reg_val,
    input  logic [15:0] idx_val,
    input  logic [15:0] base_val,
    output logic        mem_rd_en,
    output logic [15:0] mem_rd_addr,
    input  logic [15:0] mem_rd_data,
    output logic [15:0] eff_addr,
    output logic        imm_op,
    output logic        reg_op,
    output logic        implied_op,
    output logic        illegal_mode,
    output logic        done,
    output logic        ptr_wr_en,
    output logic [15:0] ptr_wr_data
);
    calc_t calc_res;

    eag_calc u_calc (
        .mode     (mode),
        .field    (addr_field),
        .pc_next  (pc_next),
        .reg_val  (reg_val),
        .idx_val  (idx_val),
        .base_val (base_val),
        .res      (calc_res)
    );

    eag_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .res          (calc_res),
        .field        (addr_field),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .eff_addr     (eff_addr),
        .imm_op       (imm_op),
        .reg_op       (reg_op),
        .implied_op   (implied_op),
        .illegal_mode (illegal_mode),
        .done         (done),
        .ptr_wr_en    (ptr_wr_en),
        .ptr_wr_data  (ptr_wr_data)
    );

    assert_wb_modes_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !mem_rd_en && !(mode == 4'd6 || mode == 4'd7)) |=> !ptr_wr_en);
endmodule

// File: tb/eff_addr_unit_tb_top.sv
module eff_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] addr_field = '0, pc_next = '0, reg_val = '0, idx_val = '0, base_val = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr, mem_rd_data, eff_addr, ptr_wr_data;
    logic        imm_op, reg_op, implied_op, illegal_mode, done, ptr_wr_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_fn(logic [15:0] a);
        return a * 16'd37 + 16'd11;
    endfunction

    assign mem_rd_data = mem_fn(mem_rd_addr);

    eff_addr_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .addr_field(addr_field),
        .pc_next(pc_next), .reg_val(reg_val), .idx_val(idx_val), .base_val(base_val),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .eff_addr(eff_addr), .imm_op(imm_op), .reg_op(reg_op), .implied_op(implied_op),
        .illegal_mode(illegal_mode), .done(done), .ptr_wr_en(ptr_wr_en),
        .ptr_wr_data(ptr_wr_data)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag(logic [3:0] m);
        case (m)
            4'd0: return "R10";
            4'd1: return "R9";
            4'd2: return "R1";
            4'd3: return "R2";
            4'd4: return "R4";
            4'd5: return "R3";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [15:0] exp_ea(logic [3:0] m, logic [15:0] f, logic [15:0] pc,
                                           logic [15:0] r, logic [15:0] x, logic [15:0] b);
        case (m)
            4'd1:  return pc - 16'd1;
            4'd2:  return f;
            4'd3:  return mem_fn(f);
            4'd5:  return r;
            4'd6:  return r;
            4'd7:  return r - 16'd1;
            4'd8:  return pc + f;
            4'd9:  return x + f;
            4'd10: return b + f;
            default: return 16'd0;
        endcase
    endfunction

    task automatic run(logic [3:0] m, logic [15:0] f, logic [15:0] pc,
                       logic [15:0] r, logic [15:0] x, logic [15:0] b);
        string t;
        logic [3:0] fl;
        t = tag(m);
        @(negedge clk);
        mode = m; addr_field = f; pc_next = pc; reg_val = r; idx_val = x; base_val = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (m == 4'd3) begin
            chk("R2 rd_en", {63'd0, mem_rd_en}, 64'd1);
            chk("R2 rd_addr", {48'd0, mem_rd_addr}, {48'd0, f});
            chk("R2 early done", {63'd0, done}, 64'd0);
            @(negedge clk);
            chk("R2 rd_en single", {63'd0, mem_rd_en}, 64'd0);
        end
        chk({t, " done R12"}, {63'd0, done}, 64'd1);
        chk({t, " ea"}, {48'd0, eff_addr}, {48'd0, exp_ea(m, f, pc, r, x, b)});
        fl = {imm_op, reg_op, implied_op, illegal_mode};
        chk({t, " flags"}, {60'd0, fl},
            {60'd0, (m == 4'd1), (m == 4'd4), (m == 4'd0), (m > 4'd10)});
        chk({t, " wb_en R12"}, {63'd0, ptr_wr_en}, {63'd0, (m == 4'd6 || m == 4'd7)});
        if (m == 4'd6) chk("R5 wb_data", {48'd0, ptr_wr_data}, {48'd0, r + 16'd1});
        if (m == 4'd7) chk("R6 wb_data", {48'd0, ptr_wr_data}, {48'd0, r - 16'd1});
        @(negedge clk);
        chk({t, " done pulse R12"}, {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 done", {63'd0, done}, 64'd0);
        chk("R13 ea", {48'd0, eff_addr}, 64'd0);
        chk("R13 flags", {59'd0, imm_op, reg_op, implied_op, illegal_mode, ptr_wr_en}, 64'd0);
        chk("R13 mem", {47'd0, mem_rd_en, mem_rd_addr}, 64'd0);
        rst = 1'b0;

        // directed corner cases
        run(4'd8, 16'd500, 16'd202, 16'd0, 16'd0, 16'd0);     // R7: 702
        run(4'd7, 16'd0, 16'd0, 16'd400, 16'd0, 16'd0);       // R6: 399
        run(4'd7, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0);         // R6 wrap to FFFF
        run(4'd6, 16'd0, 16'd0, 16'hFFFF, 16'd0, 16'd0);      // R5 wrap to 0
        run(4'd1, 16'd500, 16'd202, 16'd0, 16'd0, 16'd0);     // R9: 201
        run(4'd9, 16'd500, 16'd0, 16'd0, 16'd100, 16'd0);     // R8: 600
        run(4'd10, 16'hFFF0, 16'd0, 16'd0, 16'd0, 16'h0020);  // R8 wrap
        run(4'd3, 16'd500, 16'd0, 16'd0, 16'd0, 16'd0);       // R2
        run(4'd2, 16'd500, 16'd0, 16'd0, 16'd0, 16'd0);       // R1
        run(4'd5, 16'd0, 16'd0, 16'd400, 16'd0, 16'd0);       // R3
        run(4'd4, 16'd500, 16'd0, 16'd400, 16'd0, 16'd0);     // R4
        run(4'd0, 16'd500, 16'd0, 16'd400, 16'd0, 16'd0);     // R10
        run(4'd15, 16'd500, 16'd0, 16'd400, 16'd0, 16'd0);    // R11

        // R12: start during an indirect lookup is dropped
        @(negedge clk);
        mode = 4'd3; addr_field = 16'd77; start = 1'b1;
        @(negedge clk);
        mode = 4'd6; reg_val = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12 busy done", {63'd0, done}, 64'd1);
        chk("R12 busy ea", {48'd0, eff_addr}, {48'd0, mem_fn(16'd77)});
        chk("R12 busy no wb", {63'd0, ptr_wr_en}, 64'd0);
        @(negedge clk);
        chk("R12 dropped start", {63'd0, done}, 64'd0);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            run(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule